// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block produces the sequence of 32-bit word read addresses that fetch one screen of pixels from a linear framebuffer in memory. Raster timing drives it through two single-cycle strobes. A frame strobe rewinds it to the top of the screen. A line strobe starts the fetch of one displayed line. For each line it issues one read request per word over a valid/ready request interface, until the programmed number of words per line has been requested.

Four configuration inputs set the geometry, and they are held stable for the whole frame:

- the byte address of the first displayed line;
- the number of displayed lines, minus one;
- the number of words fetched per line, minus one;
- the line stride in words, added to the line start address for each new line.

The stride and the fetch length are separate values. Setting the stride larger than the fetch length lets a display window pan across a wider virtual screen.

A base address with bit 27 set is a known fault condition for the memory path. When a frame strobe samples such a base, the block raises a fault flag and does not scan that frame.

Back-pressure follows the usual valid/ready rules. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the request stays up and its address stays unchanged. The only exception is a frame or line strobe in that same cycle, which replaces or withdraws the request. The block never waits for `req_ready` before raising `req_valid`.

Top module: `fb_scan_addrgen`

## Requirements
- R1: After reset `req_valid` and `base_fault` are low, and no request is issued until a frame strobe with a clean base has been followed by a line strobe.
- R2: A frame strobe with bit 27 of `cfg_base` clear clears `base_fault`. The first line of that frame then starts at `cfg_base` with its two low bits forced to zero.
- R3: `req_valid` rises in the cycle after an accepted line strobe, and `req_addr` then carries that line's start address.
- R4: Within a line, each accepted request advances `req_addr` by 4. Exactly `cfg_words_m1`+1 requests are issued, after which `req_valid` falls.
- R5: While `req_valid` is high and `req_ready` is low, with no strobe in that cycle, `req_valid` stays high and `req_addr` stays unchanged in the next cycle.
- R6: Each line starts `cfg_stride`×4 bytes after the start of the previous line, whatever the line length is.
- R7: After `cfg_lines_m1`+1 lines of a frame, further line strobes issue no request until the next frame strobe.
- R8: A frame strobe with bit 27 of `cfg_base` set raises `base_fault`. The fault stays up, and line strobes are ignored, until a frame strobe samples a clean base.
- R9: A frame strobe withdraws any pending request, so `req_valid` is low in the next cycle. A line strobe in the same cycle as a frame strobe is ignored.
- R10: A line strobe that arrives before the current line has finished drops the remaining words and starts the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| line_start | input | 1 | One-cycle strobe at the start of a displayed line |
| cfg_base | input | ADDR_W | Byte address of the first displayed line |
| cfg_lines_m1 | input | LINES_W | Displayed lines minus one |
| cfg_words_m1 | input | WORDS_W | Words fetched per line minus one |
| cfg_stride | input | STRIDE_W | Line-to-line stride in words |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Byte address of the requested word |
| base_fault | output | 1 | Base address had bit 27 set at the last frame strobe |

## Verification
The bench runs several screen geometries under both a free and a stalling `req_ready`. Among them are a single-word line, a single-line frame, a stride wider than the line, and a base with stray low bits. A design that reloaded the line start from the word pointer instead of the stride would drift from the expected start addresses when panning. An off-by-one in either count would issue one word or one line too many or too few. Directed tests then cover the bit-27 fault and its recovery, a frame strobe that aborts a stalled request, and a simultaneous frame and line strobe. They also cover a line strobe that cuts a line short. A design that let a stall move the address, or let the fault leak requests, would show a wrong address or a stray valid at a known cycle.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_RUN   = 2'd1,
    SC_DONE  = 2'd2,
    SC_FAULT = 2'd3
  } scan_state_e;
endpackage

// File: rtl/scan_line_seq.sv
module scan_line_seq
  import fb_scan_pkg::*;
#(
  parameter int WA       = 30,
  parameter int LINES_W  = 8,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                line_start,
  input  logic [WA-1:0]       base_word,
  input  logic                base_bad,
  input  logic [LINES_W-1:0]  lines_m1,
  input  logic [STRIDE_W-1:0] stride,
  output logic                line_go,
  output logic [WA-1:0]       line_word,
  output logic                fault
);
  scan_state_e        state;
  logic [WA-1:0]      line_ptr;
  logic [LINES_W-1:0] line_cnt;

  assign line_go   = line_start && !frame_start && (state == SC_RUN);
  assign line_word = line_ptr;
  assign fault     = (state == SC_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SC_IDLE;
      line_ptr <= '0;
      line_cnt <= '0;
    end else if (frame_start) begin
      state    <= base_bad ? SC_FAULT : SC_RUN;
      line_ptr <= base_word;
      line_cnt <= '0;
    end else if (line_go) begin
      line_ptr <= line_ptr + WA'(stride);
      line_cnt <= line_cnt + 1'b1;
      if (line_cnt == lines_m1) state <= SC_DONE;
    end
  end

  // R7: no line is started past the programmed line count
  p_lines_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_go |-> (line_cnt <= lines_m1));
endmodule

// File: rtl/scan_word_fetch.sv
module scan_word_fetch #(
  parameter int WA      = 30,
  parameter int WORDS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               line_go,
  input  logic [WA-1:0]      line_word,
  input  logic [WORDS_W-1:0] words_m1,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [WA-1:0]      req_word
);
  logic [WORDS_W-1:0] word_cnt;
  logic               last_word;

  assign last_word = (word_cnt == words_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_word  <= '0;
      word_cnt  <= '0;
    end else if (frame_start) begin
      req_valid <= 1'b0;
    end else if (line_go) begin
      req_valid <= 1'b1;
      req_word  <= line_word;
      word_cnt  <= '0;
    end else if (req_valid && req_ready) begin
      if (last_word) begin
        req_valid <= 1'b0;
      end else begin
        req_word <= req_word + 1'b1;
        word_cnt <= word_cnt + 1'b1;
      end
    end
  end

  // R3: a started line presents its start word next cycle
  p_line_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_go |=> (req_valid && req_word == $past(line_word)));

  // R4: an accepted non-final word is followed by the next word
  p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !last_word && !frame_start && !line_go)
      |=> (req_valid && req_word == $past(req_word) + 1'b1));
endmodule

// File: rtl/fb_scan_addrgen.sv
module fb_scan_addrgen #(
  parameter int ADDR_W    = 32,
  parameter int LINES_W   = 8,
  parameter int WORDS_W   = 8,
  parameter int STRIDE_W  = 16,
  parameter int FAULT_BIT = 27
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                line_start,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [LINES_W-1:0]  cfg_lines_m1,
  input  logic [WORDS_W-1:0]  cfg_words_m1,
  input  logic [STRIDE_W-1:0] cfg_stride,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic                base_fault
);
  localparam int WA = ADDR_W - 2;

  logic          line_go;
  logic [WA-1:0] line_word;
  logic [WA-1:0] req_word;
  logic          unused_low_bits;

  assign unused_low_bits = ^cfg_base[1:0];

  scan_line_seq #(
    .WA(WA), .LINES_W(LINES_W), .STRIDE_W(STRIDE_W)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .line_start (line_start),
    .base_word  (cfg_base[ADDR_W-1:2]),
    .base_bad   (cfg_base[FAULT_BIT]),
    .lines_m1   (cfg_lines_m1),
    .stride     (cfg_stride),
    .line_go    (line_go),
    .line_word  (line_word),
    .fault      (base_fault)
  );

  scan_word_fetch #(
    .WA(WA), .WORDS_W(WORDS_W)
  ) u_word (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .line_go    (line_go),
    .line_word  (line_word),
    .words_m1   (cfg_words_m1),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_word   (req_word)
  );

  assign req_addr = {req_word, 2'b00};

  // R5: a stalled request holds
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start && !line_start)
      |=> (req_valid && $stable(req_addr)));

  // R9: a frame strobe withdraws any request
  p_frame_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !req_valid);

  // R8: a bad base at frame start raises the fault
  p_bad_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && cfg_base[FAULT_BIT]) |=> base_fault);

  // R8: no request while faulted
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    base_fault |-> !req_valid);
endmodule

// File: tb/fb_scan_addrgen_tb.sv
module fb_scan_addrgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [7:0]  cfg_lines_m1 = '0;
  logic [7:0]  cfg_words_m1 = '0;
  logic [15:0] cfg_stride = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic        base_fault;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fb_scan_addrgen u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .cfg_base(cfg_base), .cfg_lines_m1(cfg_lines_m1), .cfg_words_m1(cfg_words_m1),
    .cfg_stride(cfg_stride), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .base_fault(base_fault)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [7:0]  lines_m1;
    logic [7:0]  words_m1;
    logic [15:0] stride;
    logic        slow;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VEC [NV] = '{
    '{base: 32'h0010_0000, lines_m1: 8'd2, words_m1: 8'd3, stride: 16'd4,   slow: 1'b0},
    '{base: 32'h0020_0003, lines_m1: 8'd1, words_m1: 8'd0, stride: 16'd10,  slow: 1'b1},
    '{base: 32'h07FF_FFF0, lines_m1: 8'd3, words_m1: 8'd2, stride: 16'd100, slow: 1'b1},
    '{base: 32'h0000_4000, lines_m1: 8'd0, words_m1: 8'd7, stride: 16'd8,   slow: 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  // Accept n words of a line starting at exp_start; at entry we are at a
  // negedge just after the line strobe edge.
  task automatic collect_line(input logic [31:0] exp_start, input int n, input bit slow);
    int idx = 0;
    int cyc = 0;
    bit stalled = 1'b0;
    logic [31:0] held = '0;
    while (idx < n && cyc < 1000) begin
      if (stalled)
        check(req_valid && req_addr == held, "R5 stall hold", req_addr, held);
      req_ready = slow ? cyc[0] : 1'b1;
      stalled = req_valid && !req_ready;
      held = req_addr;
      if (req_valid && req_ready) begin
        check(req_addr == exp_start + 32'(idx) * 4, "R4/R6 word address",
              req_addr, exp_start + 32'(idx) * 4);
        idx++;
      end
      cyc++;
      @(negedge clk);
    end
    req_ready = 1'b0;
    check(idx == n, "R4 word count", 32'(idx), 32'(n));
    check(!req_valid, "R4 valid falls after last word", {31'd0, req_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] b;
    repeat (3) @(negedge clk);
    check(!req_valid, "R1 reset valid", {31'd0, req_valid}, 32'd0);
    check(!base_fault, "R1 reset fault", {31'd0, base_fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_line();
    check(!req_valid, "R1 line strobe before frame ignored", {31'd0, req_valid}, 32'd0);

    // Table-driven geometries
    for (int v = 0; v < NV; v++) begin
      cfg_base = VEC[v].base;
      cfg_lines_m1 = VEC[v].lines_m1;
      cfg_words_m1 = VEC[v].words_m1;
      cfg_stride = VEC[v].stride;
      pulse_frame();
      check(!base_fault, "R2 clean base no fault", {31'd0, base_fault}, 32'd0);
      for (int ln = 0; ln <= int'(VEC[v].lines_m1); ln++) begin
        b = (VEC[v].base & 32'hFFFF_FFFC) + 32'(ln) * 32'(VEC[v].stride) * 4;
        pulse_line();
        check(req_valid && req_addr == b, "R3/R2 line start address", req_addr, b);
        collect_line(b, int'(VEC[v].words_m1) + 1, VEC[v].slow);
      end
      pulse_line();
      check(!req_valid, "R7 extra line ignored", {31'd0, req_valid}, 32'd0);
    end

    // R8: bad base
    cfg_base = 32'h0800_0100; cfg_lines_m1 = 8'd3; cfg_words_m1 = 8'd3; cfg_stride = 16'd4;
    pulse_frame();
    check(base_fault, "R8 fault raised", {31'd0, base_fault}, 32'd1);
    pulse_line();
    check(!req_valid, "R8 line ignored under fault", {31'd0, req_valid}, 32'd0);
    check(base_fault, "R8 fault sticky", {31'd0, base_fault}, 32'd1);
    cfg_base = 32'h0000_0100;
    pulse_frame();
    check(!base_fault, "R2 fault cleared by clean base", {31'd0, base_fault}, 32'd0);

    // R9: frame strobe aborts a stalled request
    cfg_words_m1 = 8'd7;
    pulse_line();
    check(req_valid && req_addr == 32'h100, "R3 start before abort", req_addr, 32'h100);
    pulse_frame();
    check(!req_valid, "R9 abort on frame strobe", {31'd0, req_valid}, 32'd0);

    // R9: simultaneous frame and line strobe ignores the line
    frame_start = 1'b1; line_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; line_start = 1'b0;
    check(!req_valid, "R9 line ignored with frame strobe", {31'd0, req_valid}, 32'd0);
    pulse_line();
    check(req_valid && req_addr == 32'h100, "R9 first line still at base", req_addr, 32'h100);

    // R10: a line strobe cuts the line short
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check(req_addr == 32'h104, "R4 second word", req_addr, 32'h104);
    pulse_line();
    check(req_valid && req_addr == 32'h110, "R10 new line restarts", req_addr, 32'h110);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule